// File: doc/BRIEF.md
# Masked Parallel Priority Interrupt Controller

This block collects a small set of level-sensitive interrupt request lines into a pending register. A set bit stays there until software clears it. A software-written mask register, one bit per source, decides which pending bits may interrupt. A fixed-priority picker chooses the lowest-numbered eligible source and turns its index into a vector address at a programmable base with a stride of four.

A global enable flag controls whether the CPU is asked to enter an interrupt cycle. The CPU sets and clears the flag with commands. When the CPU raises its acknowledge line, the vector is driven onto the data bus, qualified by an output-enable. The enable flag is then dropped, so no further interrupt cycle is signalled until software turns it back on.

Commands arrive on a small command port: `cmd_valid` qualifies the 2-bit opcode and its source-wide argument. Mask and pending state are readable on dedicated outputs.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the pending bits, the mask bits and the enable flag are all 0, and the bus output-enable is low while acknowledge is low.
- R2: A high request line sets its pending bit at the next clock edge, and the bit stays set after the request is withdrawn.
- R3: Opcode 1 clears every pending bit whose argument bit is 1, at the next edge. A request line that is still high in that cycle keeps its bit set.
- R4: Opcode 0 loads the argument into the mask register at the next edge, and `mask_o` shows the stored value. A mask bit of 1 lets its source take part.
- R5: `ist_o` is 1 exactly when at least one pending bit has its mask bit set.
- R6: Among eligible sources, index 0 has the highest priority and higher indices have lower priority. The vector is VEC_BASE + 4 × index of the winner, or VEC_BASE when no source is eligible.
- R7: `bus_oe_o` follows `intack_i` in the same cycle. `bus_data_o` carries the vector while acknowledge is high and is 0 otherwise.
- R8: Opcode 2 sets the enable flag and opcode 3 clears it, each at the next edge. Without a command or acknowledge, the flag holds its value.
- R9: `int_cycle_o` is 1 exactly when the enable flag and `ist_o` are both 1.
- R10: An acknowledge cycle clears the enable flag at the next edge. It wins over an opcode 2 issued in the same cycle.
- R11: A pending source whose mask bit is 0 affects neither `ist_o` nor the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_SRC | Level request lines, one per source |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Opcode: 0 write mask, 1 clear pending, 2 enable on, 3 enable off |
| cmd_arg | input | N_SRC | Command argument, one bit per source |
| intack_i | input | 1 | CPU interrupt acknowledge |
| pend_o | output | N_SRC | Pending register contents |
| mask_o | output | N_SRC | Mask register contents |
| ien_o | output | 1 | Global interrupt enable flag |
| ist_o | output | 1 | An unmasked pending source exists |
| int_cycle_o | output | 1 | Request to enter an interrupt cycle |
| bus_oe_o | output | 1 | Data bus drive enable |
| bus_data_o | output | VEC_W | Vector address on the data bus |

## Verification
The bench sweeps every combination of pending pattern and mask pattern for four sources. Each case checks the status flag, the interrupt-cycle request and the vector driven during acknowledge.

This catches a picker that favours the highest index, or one that looks at pending bits without the mask. Either fault shows up as a wrong vector or a status flag raised by a masked source.

Directed cases cover a clear issued while the request is still held, which a design with clear-over-set priority would lose. They also cover an acknowledge issued together with an enable command, which a design with the wrong priority would leave enabled. Finally, they confirm that the bus is not driven outside acknowledge.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    typedef enum logic [1:0] {
        OP_MASK_WR = 2'd0,
        OP_PEND_CLR = 2'd1,
        OP_IEN_ON = 2'd2,
        OP_IEN_OFF = 2'd3
    } irq_op_e;
endpackage

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
    parameter int N_SRC = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_SRC-1:0] elig,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the lowest priority upward so the lowest index lands last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_vec.sv
module prio_irq_vec #(
    parameter int IDX_W = 2,
    parameter int VEC_W = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h40
) (
    input  logic [IDX_W-1:0] idx,
    output logic [VEC_W-1:0] vec
);
    localparam int STRIDE_SH = 2;
    always_comb begin
        vec = VEC_BASE + (VEC_W'(idx) << STRIDE_SH);
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int VEC_W = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_req,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [N_SRC-1:0] cmd_arg,
    input  logic             intack_i,
    output logic [N_SRC-1:0] pend_o,
    output logic [N_SRC-1:0] mask_o,
    output logic             ien_o,
    output logic             ist_o,
    output logic             int_cycle_o,
    output logic             bus_oe_o,
    output logic [VEC_W-1:0] bus_data_o
);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    typedef struct packed {
        logic [N_SRC-1:0] pend;
        logic [N_SRC-1:0] mask;
        logic             ien;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    irq_op_e     op_d;
    logic [N_SRC-1:0] elig_d;
    logic             any_d;
    logic [IDX_W-1:0] win_d;
    logic [VEC_W-1:0] vec_d;

    assign op_d = irq_op_e'(cmd_op);

    // Next-state: requests are sticky; a held request beats a clear.
    always_comb begin
        st_d      = st_q;
        st_d.pend = st_q.pend | irq_req;
        if (cmd_valid) begin
            case (op_d)
                OP_MASK_WR:  st_d.mask = cmd_arg;
                OP_PEND_CLR: st_d.pend = (st_q.pend & ~cmd_arg) | irq_req;
                OP_IEN_ON:   st_d.ien  = 1'b1;
                OP_IEN_OFF:  st_d.ien  = 1'b0;
            endcase
        end
        if (intack_i) begin
            st_d.ien = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign elig_d = st_q.pend & st_q.mask;

    prio_irq_pick #(
        .N_SRC(N_SRC),
        .IDX_W(IDX_W)
    ) u_pick (
        .elig(elig_d),
        .any (any_d),
        .idx (win_d)
    );

    prio_irq_vec #(
        .IDX_W   (IDX_W),
        .VEC_W   (VEC_W),
        .VEC_BASE(VEC_BASE)
    ) u_vec (
        .idx(win_d),
        .vec(vec_d)
    );

    assign pend_o      = st_q.pend;
    assign mask_o      = st_q.mask;
    assign ien_o       = st_q.ien;
    assign ist_o       = any_d;
    assign int_cycle_o = st_q.ien & any_d;
    assign bus_oe_o    = intack_i;
    assign bus_data_o  = intack_i ? vec_d : '0;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
    parameter int N_SRC = 4,
    parameter int VEC_W = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'h40
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] irq_req,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [N_SRC-1:0] cmd_arg,
    input logic             intack_i,
    input logic [N_SRC-1:0] pend_o,
    input logic [N_SRC-1:0] mask_o,
    input logic             ien_o,
    input logic             ist_o,
    input logic             int_cycle_o,
    input logic             bus_oe_o,
    input logic [VEC_W-1:0] bus_data_o
);
    logic [VEC_W-1:0] off_c;
    logic [N_SRC-1:0] elig_c;
    logic             sel_ok;
    int               offi;

    // Decode the driven vector back to an index and test it against the ports.
    always_comb begin
        elig_c = pend_o & mask_o;
        off_c  = bus_data_o - VEC_BASE;
        offi   = int'(off_c >> 2);
        sel_ok = (off_c[1:0] == 2'b00) && (offi < N_SRC);
        for (int i = 0; i < N_SRC; i++) begin
            if (i < offi && elig_c[i]) sel_ok = 1'b0;
            if (i == offi && !elig_c[i]) sel_ok = 1'b0;
        end
    end

    assert_req_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(irq_req)) & ~pend_o) == '0));

    assert_pend_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op == 2'd1) |=> (($past(pend_o) & ~pend_o) == '0));

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0) |=> (mask_o == $past(cmd_arg)));

    assert_ien_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2 && !intack_i) |=> ien_o);

    assert_ack_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        intack_i |=> !ien_o);

    assert_bus_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_o |-> (bus_data_o == '0));

    assert_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && ist_o) |-> sel_ok);

    assert_cycle_needs_ien_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_cycle_o |-> (ien_o && (elig_c != '0)));
endmodule

bind prio_irq_ctrl prio_irq_chk #(
    .N_SRC   (N_SRC),
    .VEC_W   (VEC_W),
    .VEC_BASE(VEC_BASE)
) u_chk (.*);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/100ps
module prio_irq_ctrl_tb;
    localparam int N = 4;
    localparam int VW = 8;
    localparam logic [VW-1:0] BASE = 8'h40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [N-1:0]  cmd_arg = '0;
    logic          intack_i = 1'b0;
    logic [N-1:0]  pend_o, mask_o;
    logic          ien_o, ist_o, int_cycle_o, bus_oe_o;
    logic [VW-1:0] bus_data_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.N_SRC(N), .VEC_W(VW), .VEC_BASE(BASE)) u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply inputs at the falling edge, let one rising edge pass, sample 1 ns later.
    task automatic step(input logic [N-1:0] rq, input logic v, input logic [1:0] op,
                        input logic [N-1:0] arg, input logic ack);
        @(negedge clk);
        irq_req = rq; cmd_valid = v; cmd_op = op; cmd_arg = arg; intack_i = ack;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step('0, 1'b0, 2'd0, '0, 1'b0);
    endtask

    function automatic int low_idx(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pend", int'(pend_o), 0);
        chk("R1 mask", int'(mask_o), 0);
        chk("R1 ien", int'(ien_o), 0);
        chk("R1 oe", int'(bus_oe_o), 0);
        @(negedge clk) rst_n = 1'b1;

        // R2: latch and persistence
        step(4'b0101, 1'b0, 2'd0, '0, 1'b0);
        chk("R2 latch", int'(pend_o), 5);
        idle(); idle();
        chk("R2 hold after withdraw", int'(pend_o), 5);

        // R3: clear, and clear against a held request
        step('0, 1'b1, 2'd1, 4'b0001, 1'b0);
        chk("R3 clear bit0", int'(pend_o), 4);
        step(4'b0100, 1'b1, 2'd1, 4'b0100, 1'b0);
        chk("R3 held request survives clear", int'(pend_o), 4);
        step('0, 1'b1, 2'd1, 4'b1111, 1'b0);
        chk("R3 clear all", int'(pend_o), 0);

        // R8: enable commands and hold
        step('0, 1'b1, 2'd2, '0, 1'b0);
        chk("R8 ien on", int'(ien_o), 1);
        idle();
        chk("R8 ien holds", int'(ien_o), 1);
        step('0, 1'b1, 2'd3, '0, 1'b0);
        chk("R8 ien off", int'(ien_o), 0);

        // R10: acknowledge beats a same-cycle enable
        step('0, 1'b1, 2'd2, '0, 1'b1);
        chk("R10 ack over enable", int'(ien_o), 0);
        idle();
        chk("R7 oe low after ack", int'(bus_oe_o), 0);
        chk("R7 bus zero after ack", int'(bus_data_o), 0);

        // Exhaustive sweep of pending x mask
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 16; m++) begin
                int e;
                int exp_vad;
                step('0, 1'b1, 2'd1, 4'b1111, 1'b0);
                step(4'(p), 1'b0, 2'd0, '0, 1'b0);
                step('0, 1'b1, 2'd0, 4'(m), 1'b0);
                step('0, 1'b1, 2'd2, '0, 1'b0);
                chk("R2 pend pattern", int'(pend_o), p);
                chk("R4 mask readback", int'(mask_o), m);
                e = low_idx(4'(p & m));
                exp_vad = int'(BASE) + 4 * ((e < 0) ? 0 : e);
                if ((p & m) == 0 && p != 0)
                    chk("R11 masked source ignored", int'(ist_o), 0);
                else
                    chk("R5 ist", int'(ist_o), ((p & m) != 0) ? 1 : 0);
                chk("R9 int cycle", int'(int_cycle_o), ((p & m) != 0) ? 1 : 0);
                chk("R7 bus idle", int'(bus_data_o), 0);
                @(negedge clk);
                intack_i = 1'b1;
                #1;
                chk("R7 oe with ack", int'(bus_oe_o), 1);
                chk("R6 vector", int'(bus_data_o), exp_vad);
                @(posedge clk);
                #1;
                chk("R10 ien cleared by ack", int'(ien_o), 0);
                @(negedge clk);
                intack_i = 1'b0;
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule